// File: doc/BRIEF.md
# Rate-Trimmed Nanosecond Time-of-Day Timer with Interval Pulses

This block keeps a 64-bit count of nanoseconds from a reference clock that runs faster than the nominal tick rate. On every reference edge a 32-bit rate accumulator adds a programmable addend. Each carry out of that add is one nominal tick, and each tick moves the time count forward by a programmable step in nanoseconds. Software sets the addend to ceil(2^32 / R), where R is the reference frequency divided by the nominal tick frequency and R > 1. Small changes to the addend then trim the average tick rate in fine steps.

The same tick stream drives a prescaled output clock and `NUM_PULSE` (two or three) independent interval pulse generators, such as a once-per-second marker. Each generator counts its own down-counter by the tick step. When the next step would take the count below zero, the generator raises its pulse, holds it for one prescaled clock period, and reloads from its period register. For an interval of D nanoseconds, software programs the period register with D minus one tick step.

Configuration goes through a simple single-cycle write port. The current time is read 32 bits at a time through a combinational read port.

Top module: `ptp_tod_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the time count, rate accumulator, prescale counter and pulse counters clear, and so do all configuration registers. After reset the time reads 0, every `pulse_o` bit is low, and `clk_out` is high (prescale count 0).
- R2: Each clock edge adds the addend to a 32-bit accumulator. After c edges with a constant addend A, the number of carries is floor(c·A / 2^32).
- R3: A new addend affects only later edges, and the accumulator residue is kept. The carry total is always floor(sum of the addends applied so far / 2^32).
- R4: On an edge with no carry, the time count, prescale state and pulse state hold. With addend 0 the time stays at 0 forever.
- R5: On each carry the time increases by the tick step register (address 1, bits 15:0). The step value in force at that edge is the one used.
- R6: The prescale counter counts carries modulo P, where P is the prescaler register (address 2, bits 15:0) and 0 is treated as 1. `clk_out` is high while twice the count is below P.
- R7: Pulse counters start at zero, so generator g fires on the first carry after reset. It then fires once every floor(period_g / step) + 1 carries, where period_g is at address 4+g.
- R8: After a fire, `pulse_o[g]` is high from the following cycle until P more carries have occurred. That makes it exactly one prescaled clock period wide.
- R9: A write to a pulse period register does not change the countdown already in progress. It is used from the next reload on.
- R10: With `rd_hi` = 0, `rd_data` is bits 31:0 of the time. With `rd_hi` = 1, it is bits 63:32.
- R11: Register addresses: 0 is the addend (32 bits), 1 the tick step, 2 the prescaler, and 4..3+NUM_PULSE the pulse periods. A write to any other address changes nothing observable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_hi | input | 1 | Selects the upper time word on `rd_data` |
| rd_data | output | 32 | Selected 32-bit half of the time count |
| clk_out | output | 1 | Prescaled tick clock |
| pulse_o | output | NUM_PULSE | Interval pulse outputs, one per generator |

## Verification
The reference model tracks the exact rational sum of all addends applied. If a design dropped the residue on an addend change, or stepped time on something other than a carry, its time would drift from that sum.

Directed cases cover the following:
- Addend 0 checks that the time holds.
- A period register is rewritten in the middle of a countdown. A design that reloaded at once would fire early.
- Period values that are not multiples of the step check the floor rule.
- A write to an unmapped address must leave every output on track.
- A long run at the largest step carries the time past 2^32. A wrong word select, or a carry lost between the halves, would show in the upper word.

// File: rtl/ptp_pkg.sv
// Shared constants for the nanosecond timer: register widths and the
// write-port address map. Assumes a 4-bit address space.
package ptp_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        ADR_ADDEND = 4'd0,
        ADR_STEP   = 4'd1,
        ADR_PRSC   = 4'd2,
        ADR_PER0   = 4'd4
    } reg_addr_e;
endpackage

// File: rtl/ptp_rate_accum.sv
// Rate accumulator: adds the addend to a W-bit phase register on every
// clock and reports the carry out as the nominal tick for that cycle.
// Assumes the addend is held stable by the caller between writes.
module ptp_rate_accum #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] addend,
    output logic         carry
);
    logic [W-1:0] acc_q;
    logic [W:0]   sum;

    // Full-width sum; the top bit is the tick.
    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, addend};
        carry = sum[W];
    end

    // Phase register keeps the residue across every add.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= sum[W-1:0];
    end

    // R2: a carry wraps the phase below its old value; no carry never lowers it.
    a_r2_carry_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> (acc_q < $past(acc_q)));
    a_r2_no_carry_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !carry |=> (acc_q >= $past(acc_q)));
endmodule

// File: rtl/ptp_out_div.sv
// Prescaler: counts ticks modulo the effective divide value and drives
// the prescaled clock high during the first half of each count cycle.
// Assumes prsc_eff is never zero (the top maps 0 to 1).
module ptp_out_div #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CW-1:0] prsc_eff,
    output logic          clk_out
);
    logic [CW-1:0] div_q;

    // Modulo counter advanced only by ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)   div_q <= '0;
        else if (tick) div_q <= (div_q >= prsc_eff - CW'(1)) ? '0 : div_q + CW'(1);
    end

    // Output is high while twice the count is below the divide value.
    always_comb clk_out = ({div_q, 1'b0} < {1'b0, prsc_eff});

    // R6: after a tick the count lies inside the divide range.
    a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (div_q < $past(prsc_eff)));
    // R4: without a tick the count holds.
    a_r4_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(div_q));
endmodule

// File: rtl/ptp_interval_pulse.sv
// Interval pulse generator: counts down by the tick step on each tick.
// When the next step would go below zero, it reloads from the period
// register and holds its pulse high for `width` ticks.
// Assumes the step is nonzero when pulses are wanted.
module ptp_interval_pulse #(
    parameter int PW = 32,
    parameter int TW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [TW-1:0] step,
    input  logic [PW-1:0] period,
    input  logic [CW-1:0] width,
    output logic          pulse
);
    logic [PW-1:0] cnt_q;
    logic [CW-1:0] wid_q;
    logic [PW-1:0] step_x;
    logic          fire;

    // Fire when a step would cross zero on this tick.
    always_comb begin
        step_x = {{(PW-TW){1'b0}}, step};
        fire   = tick && (cnt_q < step_x);
        pulse  = (wid_q != '0);
    end

    // Countdown with reload taken from the period register at fire time.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (fire) cnt_q <= period;
        else if (tick) cnt_q <= cnt_q - step_x;
    end

    // Pulse width counter measured in ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)                     wid_q <= '0;
        else if (fire)                  wid_q <= width;
        else if (tick && wid_q != '0)   wid_q <= wid_q - CW'(1);
    end

    // R7: a fire loads the period value in force at that edge.
    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (cnt_q == $past(period)));
    // R8: the pulse only rises after a fire.
    a_r8_rise_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> $past(fire));
    // R8: the pulse cannot end without a tick.
    a_r8_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !tick) |=> pulse);
endmodule

// File: rtl/ptp_tod_timer.sv
// Top level: configuration registers, 64-bit nanosecond time count,
// prescaler and NUM_PULSE interval pulse generators. All of them share the
// tick produced by the rate accumulator. The read port is combinational.
// Assumes 2 <= NUM_PULSE <= 12 so the period registers fit the address space.
module ptp_tod_timer
    import ptp_pkg::*;
#(
    parameter int NUM_PULSE = 3,
    parameter int TIME_W    = 64,
    parameter int STEP_W    = 16,
    parameter int PRSC_W    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [REG_W-1:0]     wr_data,
    input  logic                 rd_hi,
    output logic [REG_W-1:0]     rd_data,
    output logic                 clk_out,
    output logic [NUM_PULSE-1:0] pulse_o
);
    localparam logic [ADDR_W-1:0] PER_BASE = ADR_PER0;

    logic [REG_W-1:0]  addend_q;
    logic [STEP_W-1:0] step_q;
    logic [PRSC_W-1:0] prsc_q;
    logic [PRSC_W-1:0] prsc_eff;
    logic [REG_W-1:0]  per_q [NUM_PULSE];
    logic [TIME_W-1:0] time_q;
    logic              tick;

    // Scalar configuration registers, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addend_q <= '0;
            step_q   <= '0;
            prsc_q   <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADR_ADDEND) addend_q <= wr_data;
            if (wr_addr == ADR_STEP)   step_q   <= wr_data[STEP_W-1:0];
            if (wr_addr == ADR_PRSC)   prsc_q   <= wr_data[PRSC_W-1:0];
        end
    end

    // A prescale value of zero behaves as one.
    always_comb prsc_eff = (prsc_q == '0) ? PRSC_W'(1) : prsc_q;

    ptp_rate_accum #(.W(REG_W)) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .addend (addend_q),
        .carry  (tick)
    );

    // Time of day advances by the step on each tick only.
    always_ff @(posedge clk) begin
        if (!rst_n)    time_q <= '0;
        else if (tick) time_q <= time_q + {{(TIME_W-STEP_W){1'b0}}, step_q};
    end

    ptp_out_div #(.CW(PRSC_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .prsc_eff (prsc_eff),
        .clk_out  (clk_out)
    );

    for (genvar g = 0; g < NUM_PULSE; g++) begin : g_pulse
        localparam logic [ADDR_W-1:0] MY_ADR = PER_BASE + ADDR_W'(g);

        // Period register for this generator.
        always_ff @(posedge clk) begin
            if (!rst_n)                         per_q[g] <= '0;
            else if (wr_en && wr_addr == MY_ADR) per_q[g] <= wr_data;
        end

        ptp_interval_pulse #(.PW(REG_W), .TW(STEP_W), .CW(PRSC_W)) u_gen (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .step   (step_q),
            .period (per_q[g]),
            .width  (prsc_eff),
            .pulse  (pulse_o[g])
        );
    end

    // Word select on the time count.
    always_comb rd_data = rd_hi ? time_q[63:32] : time_q[31:0];

    // R4: the time holds on a cycle without a tick.
    a_r4_time_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(time_q));
    // R5: the time never goes back on a tick.
    a_r5_time_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && time_q[63:62] != 2'b11) |=> (time_q >= $past(time_q)));
endmodule

// File: tb/tb_ptp_tod_timer.sv
`timescale 1ns/1ps
module tb_ptp_tod_timer;
    localparam int NP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_hi = 1'b0;
    logic [31:0] rd_data;
    logic        clk_out;
    logic [NP-1:0] pulse_o;

    always #2.5 clk = ~clk;

    ptp_tod_timer #(.NUM_PULSE(NP)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_hi(rd_hi), .rd_data(rd_data),
        .clk_out(clk_out), .pulse_o(pulse_o)
    );

    int checks = 0;
    int errors = 0;

    // Reference model state (exact integer arithmetic)
    logic [127:0]    m_sum;
    longint unsigned m_car;
    longint unsigned m_time;
    longint unsigned m_next [NP];
    longint unsigned m_last [NP];
    logic [31:0]     c_add;
    longint unsigned c_step;
    longint unsigned c_prsc;
    longint unsigned c_per [NP];

    task automatic check(input bit ok, input string req, input longint unsigned act,
                         input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint unsigned peff(input longint unsigned p);
        return (p == 0) ? 1 : p;
    endfunction

    function automatic bit exp_pulse(input int g);
        return (m_last[g] != 0) && ((m_car - m_last[g]) < peff(c_prsc));
    endfunction

    function automatic bit exp_clk();
        return (2 * (m_car % peff(c_prsc))) < peff(c_prsc);
    endfunction

    // Compare all outputs against the model.
    task automatic check_all(input string req);
        logic [31:0] lo, hi;
        rd_hi = 1'b0; #0.1; lo = rd_data;
        rd_hi = 1'b1; #0.1; hi = rd_data;
        rd_hi = 1'b0;
        check({hi, lo} == 64'(m_time), req, {hi, lo}, m_time);
        check(clk_out == exp_clk(), {req, " R6 clk_out"}, clk_out, exp_clk());
        for (int g = 0; g < NP; g++)
            check(pulse_o[g] == exp_pulse(g), {req, " R7/R8 pulse"}, pulse_o[g], exp_pulse(g));
    endtask

    // One clock: drive write at current (post-negedge) point, model the edge.
    task automatic cyc(input bit we, input int adr, input logic [31:0] d,
                       input bit chk, input string req);
        wr_en = we; wr_addr = 4'(adr); wr_data = d;
        @(posedge clk);
        if (rst_n) begin
            m_sum = m_sum + 128'(c_add);
            if ((m_sum >> 32) != 128'(m_car)) begin
                m_car++;
                m_time += c_step;
                for (int g = 0; g < NP; g++)
                    if (m_car == m_next[g]) begin
                        m_last[g] = m_car;
                        m_next[g] = m_car + (c_step == 0 ? 64'd0 : c_per[g] / c_step) + 1;
                    end
            end
            if (we) begin
                if (adr == 0) c_add = d;
                else if (adr == 1) c_step = longint'(d[15:0]);
                else if (adr == 2) c_prsc = longint'(d[15:0]);
                else if (adr >= 4 && adr < 4 + NP) c_per[adr-4] = longint'(d);
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        if (chk) check_all(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        m_sum = '0; m_car = 0; m_time = 0;
        c_add = '0; c_step = 0; c_prsc = 0;
        for (int g = 0; g < NP; g++) begin
            m_next[g] = 1; m_last[g] = 0; c_per[g] = 0;
        end
        rst_n = 1'b1;
        check_all("R1 reset");
    endtask

    // Random configuration; addend last so counting starts after it.
    task automatic rand_cfg(output longint unsigned st);
        st = 1 + ($urandom % 16);
        cyc(1, 1, 32'(st), 1, "R5 cfg");
        cyc(1, 2, 32'(1 + ($urandom % 6)), 1, "R6 cfg");
        for (int g = 0; g < NP; g++)
            cyc(1, 4 + g, 32'(st * (1 + ($urandom % 12)) + (g == 2 ? $urandom % st : 0)), 1, "R7 cfg");
        cyc(1, 0, 32'h8000_0000 | $urandom, 1, "R2 cfg");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        longint unsigned st;
        void'($urandom(32'd2024));

        // R4: zero addend holds time
        do_reset();
        cyc(1, 1, 32'd5, 1, "R4");
        cyc(1, 2, 32'd3, 1, "R4");
        repeat (40) cyc(0, 0, 0, 1, "R4 hold with zero addend");

        // R2 / R5 / R6 / R7 / R8 random configurations
        for (int r = 0; r < 6; r++) begin
            do_reset();
            rand_cfg(st);
            repeat (300) cyc(0, 0, 0, 1, "R2 random run");
        end

        // R3: addend change mid-run keeps the residue
        do_reset();
        rand_cfg(st);
        repeat (77) cyc(0, 0, 0, 1, "R3 before");
        cyc(1, 0, 32'hC000_0001, 1, "R3 change");
        repeat (200) cyc(0, 0, 0, 1, "R3 after addend change");

        // R9: period rewrite mid-countdown; R11: unmapped address ignored
        do_reset();
        cyc(1, 1, 32'd4, 1, "R9 cfg");
        cyc(1, 2, 32'd2, 1, "R9 cfg");
        cyc(1, 4, 32'd36, 1, "R9 cfg");
        cyc(1, 0, 32'hFFFF_FFFF, 1, "R9 cfg");
        repeat (4) cyc(0, 0, 0, 1, "R9 before");
        cyc(1, 4, 32'd4, 1, "R9 period rewrite");
        repeat (40) cyc(0, 0, 0, 1, "R9 next reload uses new period");
        cyc(1, 3, 32'hFFFF_FFFF, 1, "R11 unmapped write");
        cyc(1, 15, 32'h0000_0001, 1, "R11 unmapped write");
        repeat (30) cyc(0, 0, 0, 1, "R11 after unmapped write");

        // R10: time crosses 2^32, upper word read
        do_reset();
        cyc(1, 1, 32'h0000_FFFF, 1, "R10 cfg");
        cyc(1, 0, 32'hFFFF_FFFF, 1, "R10 cfg");
        repeat (66000) cyc(0, 0, 0, 0, "R10");
        check_all("R10 upper word");
        check(m_time > 64'hFFFF_FFFF, "R10 model crossed 2^32", m_time, 64'h1_0000_0000);
        repeat (5) cyc(0, 0, 0, 1, "R10 after crossing");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule